// File: doc/BRIEF.md
# Shared-Memory I/O Register Overlay

This block sits between two independent memory ports and an ordinary two-port RAM. It can take over two fixed low addresses and turn them into registers, which gives both processors extra binary inputs and outputs through the memory bus they already drive. Address 0 becomes a read-only view of two external binary inputs, taken through a synchroniser. Address 1 becomes a 5-bit output drive register, and its bits drive the external output pins directly.

Each overlay has its own enable. While an enable is low, its address is a plain RAM word. While it is high, RAM accesses to that word are diverted to the register. Both ports read with one cycle of latency. When the two ports write the same target in the same cycle, the left port takes priority.

Top module: `dpmem_io_overlay`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ext_out` is 0 (all outputs off) and both read-data buses are 0.
- R2: A change on `ext_in` held across two rising edges is visible to a read of address 0 issued at the third edge. A read issued one edge earlier still returns the previous value.
- R3: With `in_ovl_en` high, a read of address 0 from either port returns the synchronised inputs in data bits [1:0], with `ext_in[0]` in bit 0, and zeros in all upper bits.
- R4: With `out_ovl_en` high, a write to address 1 from either port loads `wdata[4:0]` into the output register on that edge. The upper data bits are dropped. A bit value of 1 drives the matching `ext_out` bit on and 0 drives it off.
- R5: With `out_ovl_en` high, a read of address 1 returns the register value held before that edge in bits [4:0], with zeros above, and leaves `ext_out` unchanged.
- R6: When both ports write address 1 in the same cycle with `out_ovl_en` high, the left port's data is loaded.
- R7: With an overlay enable low, its address reads and writes the RAM word, and `ext_out` is unaffected by accesses to that address.
- R8: With `in_ovl_en` high, writes to address 0 have no effect on either the RAM word or `ext_out`.
- R9: The output register keeps its value when `in_ovl_en` or `out_ovl_en` is toggled and in cycles without an overlay write.
- R10: RAM reads return data one cycle after the access and give the old word when the other port writes the same address in that cycle. Same-cycle writes of both ports to one RAM address keep the left port's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ovl_en | input | 1 | Maps address 0 onto the input register |
| out_ovl_en | input | 1 | Maps address 1 onto the output register |
| l_en | input | 1 | Left port access strobe |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, one cycle after the read |
| r_en | input | 1 | Right port access strobe |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, one cycle after the read |
| ext_in | input | IN_W | External binary inputs, asynchronous |
| ext_out | output | OUT_W | External binary outputs, 1 = on |

## Verification
A wrong output register shows on `ext_out` in the cycle after the faulty edge. It shows again on read-back of address 1 one cycle after the read. An address-decode fault shows either as a RAM word that changed when it should not have, which appears once the overlay is disabled and the word is read, or as an overlay value returned where RAM data was expected. A synchroniser with the wrong depth shifts the edge at which a read of address 0 first returns the new input by one cycle, so reads are placed at both sides of that edge. The output register is compared every cycle against a model, so any stray load is caught within one clock.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef enum logic [1:0] {
    SRC_RAM = 2'd0,
    SRC_IN  = 2'd1,
    SRC_OUT = 2'd2
  } src_e;

  localparam int unsigned IN_SLOT  = 0;
  localparam int unsigned OUT_SLOT = 1;

  // Decide which resource an address reaches under the current enables.
  function automatic src_e classify(input logic [31:0] addr,
                                    input logic in_en,
                                    input logic out_en);
    if (in_en && addr == 32'(IN_SLOT))
      return SRC_IN;
    if (out_en && addr == 32'(OUT_SLOT))
      return SRC_OUT;
    return SRC_RAM;
  endfunction

endpackage

// File: rtl/ovl_sync.sv
module ovl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ovl_odr.sv
module ovl_odr #(
  parameter int OUT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_l,
  input  logic             hit_r,
  input  logic [OUT_W-1:0] data_l,
  input  logic [OUT_W-1:0] data_r,
  output logic [OUT_W-1:0] bits
);
  logic             load;
  logic [OUT_W-1:0] next_bits;

  assign load      = hit_l | hit_r;
  assign next_bits = hit_l ? data_l : data_r;

  always_ff @(posedge clk) begin
    if (!rst_n)    bits <= '0;
    else if (load) bits <= next_bits;
  end
endmodule

// File: rtl/ovl_port_view.sv
module ovl_port_view
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int IN_W   = 2,
  parameter int OUT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              in_en,
  input  logic              out_en,
  input  logic [IN_W-1:0]   in_bits,
  input  logic [OUT_W-1:0]  out_bits,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              ram_wr,
  output logic              ram_rd,
  output logic              odr_hit
);
  src_e              src, src_q;
  logic              is_rd, is_wr;
  logic [DATA_W-1:0] ovl_word, ovl_q;

  assign src      = classify(32'(acc_addr), in_en, out_en);
  assign is_rd    = acc_en & ~acc_we;
  assign is_wr    = acc_en & acc_we;
  assign ram_wr   = is_wr & (src == SRC_RAM);
  assign ram_rd   = is_rd;
  assign odr_hit  = is_wr & (src == SRC_OUT);
  assign ovl_word = (src == SRC_IN) ? DATA_W'(in_bits) : DATA_W'(out_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= SRC_RAM;
      ovl_q <= '0;
    end else if (is_rd) begin
      src_q <= src;
      ovl_q <= ovl_word;
    end
  end

  assign rd_data = (src_q == SRC_RAM) ? ram_q : ovl_q;
endmodule

// File: rtl/ovl_ram.sv
module ovl_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_l,
  input  logic              re_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] wd_l,
  output logic [DATA_W-1:0] q_l,
  input  logic              we_r,
  input  logic              re_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wd_r,
  output logic [DATA_W-1:0] q_r
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  // Right first, left last: left data survives a same-address collision.
  always_ff @(posedge clk) begin
    if (we_r) mem[addr_r] <= wd_r;
    if (we_l) mem[addr_l] <= wd_l;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_l <= '0;
      q_r <= '0;
    end else begin
      if (re_l) q_l <= mem[addr_l];
      if (re_r) q_r <= mem[addr_r];
    end
  end
endmodule

// File: rtl/dpmem_io_overlay.sv
module dpmem_io_overlay #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int IN_W   = 2,
  parameter int OUT_W  = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_ovl_en,
  input  logic              out_ovl_en,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic [IN_W-1:0]   ext_in,
  output logic [OUT_W-1:0]  ext_out
);
  localparam int NPORT = 2;
  localparam int PL    = 0;
  localparam int PR    = 1;

  logic [IN_W-1:0]   in_sync;
  logic [OUT_W-1:0]  odr_bits;
  logic              p_en   [NPORT];
  logic              p_we   [NPORT];
  logic [ADDR_W-1:0] p_addr [NPORT];
  logic [DATA_W-1:0] p_wd   [NPORT];
  logic [DATA_W-1:0] p_q    [NPORT];
  logic [DATA_W-1:0] p_rd   [NPORT];
  logic              p_ramw [NPORT];
  logic              p_ramr [NPORT];
  logic              p_hit  [NPORT];
  logic              odr_load_l, odr_load_r;

  assign p_en[PL]   = l_en;    assign p_en[PR]   = r_en;
  assign p_we[PL]   = l_we;    assign p_we[PR]   = r_we;
  assign p_addr[PL] = l_addr;  assign p_addr[PR] = r_addr;
  assign p_wd[PL]   = l_wdata; assign p_wd[PR]   = r_wdata;

  ovl_sync #(.WIDTH(IN_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_in), .q(in_sync)
  );

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      ovl_port_view #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_view (
        .clk(clk), .rst_n(rst_n),
        .acc_en(p_en[p]), .acc_we(p_we[p]), .acc_addr(p_addr[p]),
        .in_en(in_ovl_en), .out_en(out_ovl_en),
        .in_bits(in_sync), .out_bits(odr_bits),
        .ram_q(p_q[p]), .rd_data(p_rd[p]),
        .ram_wr(p_ramw[p]), .ram_rd(p_ramr[p]), .odr_hit(p_hit[p])
      );
    end
  endgenerate

  assign odr_load_l = p_hit[PL];
  assign odr_load_r = p_hit[PR];

  ovl_odr #(.OUT_W(OUT_W)) u_odr (
    .clk(clk), .rst_n(rst_n),
    .hit_l(odr_load_l), .hit_r(odr_load_r),
    .data_l(l_wdata[OUT_W-1:0]), .data_r(r_wdata[OUT_W-1:0]),
    .bits(odr_bits)
  );

  ovl_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we_l(p_ramw[PL]), .re_l(p_ramr[PL]), .addr_l(l_addr), .wd_l(l_wdata), .q_l(p_q[PL]),
    .we_r(p_ramw[PR]), .re_r(p_ramr[PR]), .addr_r(r_addr), .wd_r(r_wdata), .q_r(p_q[PR])
  );

  assign l_rdata = p_rd[PL];
  assign r_rdata = p_rd[PR];
  assign ext_out = odr_bits;
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int IN_W   = 2,
  parameter int OUT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ovl_en,
  input logic              out_ovl_en,
  input logic              l_en,
  input logic              l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic [DATA_W-1:0] l_rdata,
  input logic              r_en,
  input logic              r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_wdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic [OUT_W-1:0]  ext_out,
  input logic              odr_load_l,
  input logic              odr_load_r
);
  p_left_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    odr_load_l |=> ext_out == $past(l_wdata[OUT_W-1:0]));

  p_right_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (odr_load_r && !odr_load_l) |=> ext_out == $past(r_wdata[OUT_W-1:0]));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!odr_load_l && !odr_load_r) |=> $stable(ext_out));

  p_load_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ovl_en |-> (!odr_load_l && !odr_load_r));

  p_in_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && !l_we && in_ovl_en && l_addr == ADDR_W'(0)) |=> l_rdata[DATA_W-1:IN_W] == '0);

  p_out_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && !r_we && out_ovl_en && r_addr == ADDR_W'(1)) |=> r_rdata == DATA_W'($past(ext_out)));
endmodule

bind dpmem_io_overlay ovl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/dpmem_io_overlay_tb.sv
module dpmem_io_overlay_tb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic in_ovl_en = 0, out_ovl_en = 0;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic [1:0] ext_in = '0;
  logic [4:0] ext_out;

  always #5 clk = ~clk;

  dpmem_io_overlay u_dut (
    .clk(clk), .rst_n(rst_n), .in_ovl_en(in_ovl_en), .out_ovl_en(out_ovl_en),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .ext_in(ext_in), .ext_out(ext_out)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // Behavioural reference state
  int m_mem [DEPTH];
  int m_odr = 0, m_s1 = 0, m_s2 = 0;
  int exp_l = 0, exp_r = 0;
  bit chk_l = 0, chk_r = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_read(int a);
    if (in_ovl_en && a == 0) return m_s2;
    if (out_ovl_en && a == 1) return m_odr;
    return m_mem[a];
  endfunction

  task automatic ref_write(int a, int d);
    if (in_ovl_en && a == 0) return;
    if (out_ovl_en && a == 1) begin m_odr = d & 5'h1f; return; end
    m_mem[a] = d;
  endtask

  // One clock: drive, let the edge pass, update model, compare at negedge.
  task automatic cyc(string tag,
                     bit le, bit lw, int la, int ld,
                     bit re, bit rw, int ra, int rd);
    l_en = le; l_we = lw; l_addr = AW'(la); l_wdata = DW'(ld);
    r_en = re; r_we = rw; r_addr = AW'(ra); r_wdata = DW'(rd);
    @(posedge clk);
    #1;
    chk_l = le && !lw; chk_r = re && !rw;
    if (chk_l) exp_l = ref_read(la);
    if (chk_r) exp_r = ref_read(ra);
    if (re && rw) ref_write(ra, rd);
    if (le && lw) ref_write(la, ld);
    m_s2 = m_s1; m_s1 = int'(ext_in);
    @(negedge clk);
    check({tag, " ext_out"}, int'(ext_out), m_odr);
    if (chk_l) check({tag, " l_rdata"}, int'(l_rdata), exp_l);
    if (chk_r) check({tag, " r_rdata"}, int'(r_rdata), exp_r);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ext_out in reset", int'(ext_out), 0);
    check("R1 l_rdata in reset", int'(l_rdata), 0);
    check("R1 r_rdata in reset", int'(r_rdata), 0);
    rst_n = 1;
    idle("R1 first cycle");
    check("R1 r_rdata after reset", int'(r_rdata), 0);

    // R7/R10: overlays off, fill RAM from both ports, read back
    for (int i = 0; i < DEPTH; i += 2)
      cyc("R7 fill", 1, 1, i, 16'h1000 + i * 17, 1, 1, i + 1, 16'h2000 + i * 13);
    for (int i = 0; i < DEPTH; i++)
      cyc("R10 readback", 1, 0, i, 0, 1, 0, DEPTH - 1 - i, 0);

    // R2/R3: input overlay, synchroniser timing
    in_ovl_en = 1; out_ovl_en = 1;
    ext_in = 2'b00;
    idle("R2 settle"); idle("R2 settle");
    ext_in = 2'b01;
    cyc("R2 early read", 1, 0, 0, 0, 1, 0, 0, 0);
    cyc("R2 edge read", 1, 0, 0, 0, 1, 0, 0, 0);
    cyc("R3 new value", 1, 0, 0, 0, 1, 0, 0, 0);
    ext_in = 2'b10;
    idle("R2 wait"); idle("R2 wait");
    cyc("R3 bit order", 1, 0, 0, 0, 1, 0, 0, 0);
    ext_in = 2'b11;
    idle("R2 wait"); idle("R2 wait");
    cyc("R3 both set", 0, 0, 0, 0, 1, 0, 0, 0);

    // R4/R5: output register
    cyc("R4 left write", 1, 1, 1, 16'hABD5, 0, 0, 0, 0);
    cyc("R5 right readback", 0, 0, 0, 0, 1, 0, 1, 0);
    cyc("R5 readback again", 1, 0, 1, 0, 1, 0, 1, 0);
    cyc("R4 right write", 0, 0, 0, 0, 1, 1, 1, 16'hFFEA);
    cyc("R5 read during write", 1, 0, 1, 0, 1, 1, 1, 16'h0003);
    cyc("R5 read after", 1, 0, 1, 0, 0, 0, 0, 0);

    // R6: simultaneous writes
    cyc("R6 collision", 1, 1, 1, 16'h0011, 1, 1, 1, 16'h000E);
    cyc("R6 collision 2", 1, 1, 1, 16'h0000, 1, 1, 1, 16'h001F);

    // R8: writes to address 0 under input overlay are dropped
    cyc("R4 set pattern", 1, 1, 1, 16'h0019, 0, 0, 0, 0);
    cyc("R8 write addr0", 1, 1, 0, 16'h5A5A, 1, 1, 0, 16'hA5A5);
    cyc("R8 read addr0", 1, 0, 0, 0, 0, 0, 0, 0);
    in_ovl_en = 0;
    cyc("R8 RAM word intact", 1, 0, 0, 0, 1, 0, 0, 0);

    // R9: toggling enables does not disturb output register
    in_ovl_en = 1; idle("R9 in toggle");
    in_ovl_en = 0; idle("R9 in toggle");
    out_ovl_en = 0; idle("R9 out off");
    out_ovl_en = 1; idle("R9 out on");

    // R7: output overlay off, address 1 is RAM
    out_ovl_en = 0;
    cyc("R7 write addr1 RAM", 1, 1, 1, 16'h0BEE, 0, 0, 0, 0);
    cyc("R7 read addr1 RAM", 1, 0, 1, 0, 1, 0, 1, 0);
    out_ovl_en = 1;
    cyc("R9 reg kept", 1, 0, 1, 0, 0, 0, 0, 0);
    out_ovl_en = 0;
    cyc("R7 RAM kept", 0, 0, 0, 0, 1, 0, 1, 0);
    out_ovl_en = 1;

    // R10: RAM collisions and read-during-write
    cyc("R10 both write", 1, 1, 7, 16'h7777, 1, 1, 7, 16'h8888);
    cyc("R10 read", 1, 0, 7, 0, 0, 0, 0, 0);
    cyc("R10 read old", 1, 0, 9, 0, 1, 1, 9, 16'h9999);
    cyc("R10 read new", 1, 0, 9, 0, 0, 0, 0, 0);
    idle("end");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule